// File: doc/BRIEF.md
# Port Statistics Snapshot Unit

This block holds a bank of event counters, `NCNT` for each of `NPORTS` ports, each advanced by a one-cycle strobe. A host freezes all the counters of one port into a capture bank and then reads any single captured counter back as two 16-bit halves. All access goes through a small register window of three 16-bit registers: an operation register and a pair of result registers.

A snapshot is started by writing a capture opcode with a port number into the operation register. The capture bank is then filled one counter per cycle. During that time bit 15 of the operation register reads 1, and the host polls it until it reads 0. A fetch opcode with a counter index then places that captured counter into the result registers within one cycle. The live counters never stop counting. The captured values change only when a new snapshot runs. A 64-bit statistic is held in two neighbouring counters: the low word at an even base index and the high word at the next index. Both words come from the same snapshot.

Top module: `port_stat_snap`

## Requirements
- R1: After reset every live counter, every captured value and both result registers are zero, and all three window registers (0x1D, 0x1E, 0x1F) read 0x0000.
- R2: Input strobe `inc_i[p*NCNT+k]` high at a clock edge adds one to counter k of port p at that edge.
- R3: A counter at its all-ones value (2^CW-1) stays there when strobed and does not wrap.
- R4: Writing 0xDC00 | port (port in bits 7:0) to offset 0x1D starts a snapshot of that port. Bit 15 of 0x1D reads 1 for exactly NCNT cycles, starting in the cycle after the write. A port number of NPORTS or more captures zeros.
- R5: Writing 0xCC00 | index (index in bits 7:0) to 0x1D when not busy loads the captured counter. In the next cycle its bits 31:16 read at 0x1E and its bits 15:0 read at 0x1F. Offset 0x1D reads {busy, bits 14:0 of the last accepted operation}. A fetch never sets busy.
- R6: Live counters keep counting during and after a snapshot. The captured values do not change except while a snapshot is running.
- R7: A fetch of an index of NCNT or more puts zero in both result registers.
- R8: A write to 0x1D while busy reads 1 is ignored. The result registers, the captured port and the operation readback are all left unchanged.
- R9: Two consecutive indices k and k+1 come from the same snapshot, so the host can read them as the low and high words of one 64-bit value.
- R10: Writes to 0x1D whose upper byte is neither 0xDC nor 0xCC are ignored. Writes to any other offset are ignored. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_i | input | NPORTS*NCNT | Increment strobes, one per counter, port-major |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register offset for reads and writes |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Read data for `addr`, combinational |

## Verification
The embedded assertions check several rules on every cycle:
- a strobe advances a live counter by one;
- a saturated counter stays saturated;
- busy drops only after the last counter has been copied;
- the capture bank stays frozen while idle;
- the result registers stay stable while busy;
- a fetch of an out-of-range index yields zero.

Only the bench scenarios can show the rest. These include the exact busy length seen at the register window, the value each fetched counter carries (including a count that reaches the high result half), and the pairing of two indices into a 64-bit value. They also cover operations dropped while busy and the rejection of unknown opcodes and stray offsets.

// File: rtl/port_stat_snap.sv
module port_stat_snap #(
  parameter int NPORTS = 4,
  parameter int NCNT   = 8,
  parameter int CW     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORTS*NCNT-1:0] inc_i,
  input  logic                   wr_en,
  input  logic [4:0]             addr,
  input  logic [15:0]            wdata,
  output logic [15:0]            rdata
);
  localparam int NLIVE = NPORTS * NCNT;
  localparam int PTRW  = (NCNT > 1) ? $clog2(NCNT) : 1;
  localparam logic [4:0] A_OP = 5'h1D;
  localparam logic [4:0] A_HI = 5'h1E;
  localparam logic [4:0] A_LO = 5'h1F;
  localparam logic [7:0] OP_SNAP = 8'hDC;
  localparam logic [7:0] OP_READ = 8'hCC;

  logic [NLIVE*CW-1:0] live_w;
  logic [NCNT*CW-1:0]  snap_q;
  logic                busy_q;
  logic [PTRW-1:0]     ptr_q;
  logic [7:0]          port_q;
  logic [14:0]         op_q;
  logic [31:0]         res_q;
  logic [CW-1:0]       src;
  logic [31:0]         fetch;

  wire op_wr   = wr_en && (addr == A_OP) && !busy_q;
  wire snap_go = op_wr && (wdata[15:8] == OP_SNAP);
  wire read_go = op_wr && (wdata[15:8] == OP_READ);
  wire last    = (ptr_q == PTRW'(NCNT - 1));

  for (genvar i = 0; i < NLIVE; i++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q <= '0;
      else if (inc_i[i] && (cnt_q != '1))
        cnt_q <= cnt_q + 1'b1;
    end
    assign live_w[i*CW +: CW] = cnt_q;
  end

  always_comb begin
    src = '0;
    for (int p = 0; p < NPORTS; p++)
      for (int k = 0; k < NCNT; k++)
        if (port_q == 8'(p) && ptr_q == PTRW'(k))
          src = live_w[(p*NCNT+k)*CW +: CW];
  end

  always_comb begin
    fetch = '0;
    for (int k = 0; k < NCNT; k++)
      if (wdata[7:0] == 8'(k))
        fetch = 32'(snap_q[k*CW +: CW]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (busy_q) begin
      for (int k = 0; k < NCNT; k++)
        if (ptr_q == PTRW'(k))
          snap_q[k*CW +: CW] <= src;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      port_q <= '0;
      op_q   <= '0;
      res_q  <= '0;
    end else begin
      if (snap_go) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
        port_q <= wdata[7:0];
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      ptr_q  <= ptr_q + 1'b1;
      end
      if (snap_go || read_go) op_q <= wdata[14:0];
      if (read_go) res_q <= fetch;
    end
  end

  always_comb begin
    case (addr)
      A_OP:    rdata = {busy_q, op_q};
      A_HI:    rdata = res_q[31:16];
      A_LO:    rdata = res_q[15:0];
      default: rdata = '0;
    endcase
  end

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i[0] && live_w[CW-1:0] != '1) |=> live_w[CW-1:0] == $past(live_w[CW-1:0]) + CW'(1));

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_w[CW-1:0] == '1) |=> (live_w[CW-1:0] == '1));

  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(ptr_q) == PTRW'(NCNT - 1)));

  // R6
  bank_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(snap_q));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(res_q));

  // R7
  range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_OP && !busy_q && wdata[15:8] == OP_READ && wdata[7:0] >= 8'(NCNT))
      |=> (res_q == '0));
endmodule

// File: tb/sim_port_stat_snap.sv
`timescale 1ns/1ps
module sim_port_stat_snap;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] inc0 = '0;
  logic [31:0] inc1 = '0;
  logic wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata0, rdata1;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  port_stat_snap #(.NPORTS(4), .NCNT(8), .CW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .inc_i(inc0), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata0));

  port_stat_snap #(.NPORTS(4), .NCNT(8), .CW(4)) u1 (
    .clk(clk), .rst_n(rst_n), .inc_i(inc1), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata1));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] v0, output logic [15:0] v1);
    addr = a;
    #1;
    v0 = rdata0; v1 = rdata1;
    addr = '0;
  endtask

  task automatic pulse0(int idx, int n);
    @(negedge clk);
    inc0[idx] = 1'b1;
    repeat (n) @(negedge clk);
    inc0[idx] = 1'b0;
  endtask

  task automatic snap(int port, output int cyc);
    logic [15:0] v0, v1;
    wr(5'h1D, 16'hDC00 | 16'(port));
    cyc = 0;
    for (int i = 0; i < 20; i++) begin
      rd(5'h1D, v0, v1);
      if (!v0[15]) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic fetch(int idx, output logic [31:0] r0, output logic [31:0] r1);
    logic [15:0] h0, h1, l0, l1;
    wr(5'h1D, 16'hCC00 | 16'(idx));
    rd(5'h1E, h0, h1);
    rd(5'h1F, l0, l1);
    r0 = {h0, l0}; r1 = {h1, l1};
  endtask

  task automatic t_reset();
    logic [15:0] v0, v1;
    rd(5'h1D, v0, v1); chk("R1 op reg", v0, 0); chk("R1 op reg u1", v1, 0);
    rd(5'h1E, v0, v1); chk("R1 hi reg", v0, 0);
    rd(5'h1F, v0, v1); chk("R1 lo reg", v0, 0);
  endtask

  task automatic t_count_snap();
    int cyc;
    logic [31:0] r0, r1;
    logic [15:0] v0, v1;
    for (int k = 0; k < 8; k++) pulse0(8 + k, (k + 1) * 3);
    snap(1, cyc);
    chk("R4 busy length", 64'(cyc), 8);
    for (int k = 0; k < 8; k++) begin
      fetch(k, r0, r1);
      chk("R2 R5 fetched count", r0, 64'((k + 1) * 3));
    end
    rd(5'h1D, v0, v1);
    chk("R5 op readback", v0, 16'h4C07);
  endtask

  task automatic t_live();
    int cyc;
    logic [31:0] r0, r1;
    pulse0(8, 5);
    fetch(0, r0, r1);
    chk("R6 bank frozen", r0, 3);
    snap(1, cyc);
    fetch(0, r0, r1);
    chk("R6 live kept counting", r0, 8);
  endtask

  task automatic t_range();
    logic [31:0] r0, r1;
    fetch(1, r0, r1);
    chk("R5 nonzero before range", r0, 6);
    fetch(8, r0, r1);
    chk("R7 index NCNT", r0, 0);
    fetch(1, r0, r1);
    fetch(255, r0, r1);
    chk("R7 index 255", r0, 0);
  endtask

  task automatic t_busy();
    logic [31:0] r0, r1;
    logic [15:0] v0, v1;
    fetch(2, r0, r1);
    chk("R5 port1 c2", r0, 9);
    wr(5'h1D, 16'hDC01);
    rd(5'h1D, v0, v1);
    chk("R4 busy read during capture", v0, 16'hDC01);
    wr(5'h1D, 16'hCC00);
    wr(5'h1D, 16'hDC03);
    rd(5'h1E, v0, v1); chk("R8 hi unchanged", v0, 0);
    rd(5'h1F, v0, v1); chk("R8 lo unchanged", v0, 9);
    rd(5'h1D, v0, v1); chk("R8 op readback unchanged", v0, 16'hDC01);
    repeat (10) @(negedge clk);
    fetch(0, r0, r1);
    chk("R8 captured port kept", r0, 8);
  endtask

  task automatic t_bad();
    logic [31:0] r0, r1;
    logic [15:0] v0, v1;
    fetch(3, r0, r1);
    chk("R5 port1 c3", r0, 12);
    wr(5'h1D, 16'h1234);
    wr(5'h1D, 16'h8C00);
    rd(5'h1D, v0, v1); chk("R10 bad opcode ignored", v0, 16'h4C03);
    wr(5'h1E, 16'hFFFF);
    rd(5'h1E, v0, v1); chk("R10 hi write ignored", v0, 0);
    rd(5'h1F, v0, v1); chk("R10 lo kept", v0, 12);
    rd(5'h05, v0, v1); chk("R10 stray offset reads 0", v0, 0);
  endtask

  task automatic t_wide();
    int cyc;
    logic [31:0] lo0, hi0, r1;
    pulse0(2*8 + 5, 70000);
    pulse0(2*8 + 6, 3);
    snap(2, cyc);
    chk("R4 busy length port2", 64'(cyc), 8);
    fetch(5, lo0, r1);
    chk("R5 upper half nonzero", lo0, 32'h0001_1170);
    fetch(6, hi0, r1);
    chk("R9 pair high word", hi0, 3);
    chk("R9 composed 64-bit", {hi0, lo0}, 64'h0000_0003_0001_1170);
  endtask

  task automatic t_outport();
    int cyc;
    logic [31:0] r0, r1;
    snap(7, cyc);
    chk("R4 busy length bad port", 64'(cyc), 8);
    fetch(5, r0, r1);
    chk("R4 bad port captures zero", r0, 0);
  endtask

  task automatic t_sat();
    int cyc;
    logic [31:0] r0, r1;
    @(negedge clk);
    inc1[0] = 1'b1;
    repeat (20) @(negedge clk);
    inc1[0] = 1'b0;
    snap(0, cyc);
    fetch(0, r0, r1);
    chk("R3 saturated at 15", r1, 15);
    fetch(0, r0, r1);
    chk("R2 untouched counter", r0, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_snap();
    t_live();
    t_range();
    t_busy();
    t_bad();
    t_wide();
    t_outport();
    t_sat();
    done = 1;
    report();
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end
endmodule